// File: doc/BRIEF.md
# SPI Register-Access Front End

This block is the serial slave side of a small timekeeping peripheral. It turns SPI transactions into accesses on a 16-entry byte register file that sits next to it in the timekeeping logic. Select is active high: a transaction runs for as long as the select line is held high. The first byte is a command. Its upper nibble says whether the access is a read or a write, and its lower nibble gives the starting register. Every later byte in the same transaction goes to, or comes from, the next register in turn. The address wraps from the top register back to register zero.

SCLK, select and MOSI are sampled by the system clock through a short synchroniser chain, and their edges are detected on the synchronised copies. Data moves most significant bit first in SPI mode 0: MOSI is captured when SCLK rises and MISO is updated when SCLK falls. Toward the register file the block drives a one-cycle write strobe with an address and data, and a read address. The register file must answer that read address combinationally on the read-data input.

The control state machine has five states:
- ST_IDLE: select is low. When select rises it moves to ST_CMD.
- ST_CMD: it waits for the first complete byte. A write prefix moves it to ST_WRITE, a read prefix moves it to ST_READ, and any other value moves it to ST_IGNORE.
- ST_WRITE: each complete byte is written to the current register, then the address is stepped.
- ST_READ: the current register is loaded into the transmit shifter, and the address is stepped after each byte.
- ST_IGNORE: nothing happens until select falls.

Whenever select goes low, the machine returns to ST_IDLE from any state.

Top module: `spi_regs_frontend`

## Requirements
- R1: After reset, and while select is low, `spi_miso` is 0 and `rf_we` is 0.
- R2: A command byte whose upper nibble is 0x1 starts a write at the address in its lower nibble. Each following complete byte produces exactly one `rf_we` pulse, carrying that byte and the current address, and the address then increments.
- R3: A command byte whose upper nibble is 0x9 starts a read. Each following byte slot returns the register at the current address on `spi_miso`, and the address then increments.
- R4: During a burst in either direction, the address wraps from 0xF to 0x0.
- R5: A byte cut short because select falls before its eighth rising SCLK edge is discarded, and no register is written for it.
- R6: A command byte with any upper nibble other than 0x1 or 0x9 is ignored. No register is written, and `spi_miso` stays 0 until select falls.
- R7: Data is carried most significant bit first. MOSI is captured on the rising SCLK edge, and MISO changes after the falling edge. The first bit of each read byte is therefore valid before the first rising edge of that byte.
- R8: `spi_miso` is 0 throughout the command byte and throughout write transactions.
- R9: Each new select-high interval is decoded from scratch, starting with a command byte, whatever the previous transaction was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the SPI pins |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs | input | 1 | Active-high chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| rf_we | output | 1 | One-cycle register write strobe |
| rf_waddr | output | 4 | Register write address |
| rf_wdata | output | 8 | Register write data |
| rf_raddr | output | 4 | Register read address |
| rf_rdata | input | 8 | Register read data, combinational from `rf_raddr` |

## Verification
The hardest case to reach is a byte that is cut off in the middle. The bench stops toggling SCLK after a few bits of a data byte, drops select, and then reads the following register back through a fresh read transaction to show that it did not change. The second hard case is the handoff at a read byte boundary. The transmit shifter must be reloaded between the eighth rising edge and the next falling edge. Long bursts that run across the 0xF-to-0x0 wrap exercise this handoff many times in a row.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int PFX_W  = DATA_W - ADDR_W;
    localparam int CNT_W  = $clog2(DATA_W);

    // command prefixes in the upper nibble
    localparam logic [PFX_W-1:0] PFX_WRITE = 4'b0001;
    localparam logic [PFX_W-1:0] PFX_READ  = 4'b1001;

    // pin positions inside the synchroniser vector
    localparam int PIN_SCLK = 0;
    localparam int PIN_CS   = 1;
    localparam int PIN_MOSI = 2;
    localparam int PIN_N    = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WRITE,
        ST_READ,
        ST_IGNORE
    } fe_state_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES   = 2,
    parameter int PINS     = 3,
    parameter int EDGE_IDX = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_s,
    output logic            edge_rise,
    output logic            edge_fall
);
    logic edge_prev;

    // one synchroniser chain per pin
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], pin_in[p]};
        end
        assign pin_s[p] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) edge_prev <= 1'b0;
        else        edge_prev <= pin_s[EDGE_IDX];
    end

    assign edge_rise =  pin_s[EDGE_IDX] & ~edge_prev;
    assign edge_fall = ~pin_s[EDGE_IDX] &  edge_prev;
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
    import spi_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              miso
);
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else if (!cs_active) begin
            bit_cnt   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (sclk_rise) begin
                rx_sh <= {rx_sh[DATA_W-3:0], mosi_s};
                if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                    bit_cnt   <= '0;
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sh, mosi_s};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            tx_sh <= '0;
            miso  <= 1'b0;
        end else if (tx_load) begin
            tx_sh <= tx_data;
        end else if (sclk_fall) begin
            miso  <= tx_sh[DATA_W-1];
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);
    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> (bit_cnt == '0));
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
    import spi_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              tx_load
);
    fe_state_t        state_q, state_d;
    logic [PFX_W-1:0] prefix;

    assign prefix = rx_byte[DATA_W-1:ADDR_W];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_active) state_d = ST_CMD;
            ST_CMD: begin
                if (byte_done) begin
                    if (prefix == PFX_WRITE)     state_d = ST_WRITE;
                    else if (prefix == PFX_READ) state_d = ST_READ;
                    else                         state_d = ST_IGNORE;
                end
            end
            ST_WRITE:  state_d = ST_WRITE;
            ST_READ:   state_d = ST_READ;
            ST_IGNORE: state_d = ST_IGNORE;
            default:   state_d = ST_IDLE;
        endcase
        if (!cs_active) state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            cur_addr <= '0;
            tx_load  <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            tx_load <= 1'b0;
            if (cs_active && byte_done) begin
                unique case (state_q)
                    ST_CMD: begin
                        cur_addr <= rx_byte[ADDR_W-1:0];
                        tx_load  <= (prefix == PFX_READ);
                    end
                    ST_WRITE: begin
                        wr_en    <= 1'b1;
                        wr_addr  <= cur_addr;
                        wr_data  <= rx_byte;
                        cur_addr <= cur_addr + 1'b1;
                    end
                    ST_READ: begin
                        cur_addr <= cur_addr + 1'b1;
                        tx_load  <= 1'b1;
                    end
                    ST_IDLE, ST_IGNORE: ;
                    default: ;
                endcase
            end
        end
    end

    // R5
    wr_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(byte_done));
    // R6
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> (!wr_en && !tx_load));
    // R9
    cs_drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> (state_q == ST_IDLE));
    // R3
    load_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> (state_q == ST_READ));
endmodule

// File: rtl/spi_regs_frontend.sv
module spi_regs_frontend
    import spi_rf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [ADDR_W-1:0] rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata
);
    logic [PIN_N-1:0]  pins_raw, pins_s;
    logic              sclk_rise, sclk_fall;
    logic              byte_done, tx_load;
    logic [DATA_W-1:0] rx_byte;

    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_SCLK] = spi_sclk;
        pins_raw[PIN_CS]   = spi_cs;
        pins_raw[PIN_MOSI] = spi_mosi;
    end

    spi_pin_sync #(
        .STAGES   (SYNC_STAGES),
        .PINS     (PIN_N),
        .EDGE_IDX (PIN_SCLK)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pins_raw),
        .pin_s     (pins_s),
        .edge_rise (sclk_rise),
        .edge_fall (sclk_fall)
    );

    spi_byte_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (pins_s[PIN_CS]),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (pins_s[PIN_MOSI]),
        .tx_load   (tx_load),
        .tx_data   (rf_rdata),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (spi_miso)
    );

    spi_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (pins_s[PIN_CS]),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .wr_en     (rf_we),
        .wr_addr   (rf_waddr),
        .wr_data   (rf_wdata),
        .cur_addr  (rf_raddr),
        .tx_load   (tx_load)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_s[PIN_CS] |=> (!spi_miso && !rf_we));
endmodule

// File: tb/test_spi_regs_frontend.sv
module test_spi_regs_frontend;
    localparam int HALF = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0, spi_cs = 1'b0, spi_mosi = 1'b0;
    logic       spi_miso, rf_we;
    logic [3:0] rf_waddr, rf_raddr;
    logic [7:0] rf_wdata, rf_rdata;

    logic [7:0]  regs   [16];
    logic [7:0]  shadow [16];
    logic [11:0] exp_wr [$];
    logic [7:0]  exp_rd [$];
    int          n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    spi_regs_frontend i_spi_regs_frontend (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs(spi_cs),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata)
    );

    // register file model
    assign rf_rdata = regs[rf_raddr];
    always @(posedge clk) if (rf_we) regs[rf_waddr] <= rf_wdata;

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected writes as the design produces them
    always @(negedge clk) begin
        if (rst_n && rf_we) begin
            if (exp_wr.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL R2 unexpected write actual=0x%0h expected=none",
                         {rf_waddr, rf_wdata});
            end else begin
                chk("R2 write addr/data", {rf_waddr, rf_wdata}, exp_wr.pop_front());
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits = 8);
        rx = '0;
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = tx[7-i];
            tick(HALF);
            rx[7-i] = spi_miso;
            spi_sclk = 1'b1;
            tick(HALF);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic cs_on();
        spi_cs = 1'b1;
        tick(HALF);
    endtask

    task automatic cs_off();
        tick(HALF);
        spi_cs = 1'b0;
        tick(2 * HALF);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d [4], input int n);
        logic [7:0] rx;
        cs_on();
        xfer(8'h10 | {4'h0, a}, rx);
        chk("R8 miso during write command", rx, 0);
        for (int k = 0; k < n; k++) begin
            logic [3:0] aa = a + 4'(k);
            exp_wr.push_back({aa, d[k]});
            shadow[aa] = d[k];
            xfer(d[k], rx);
            chk("R8 miso during write data", rx, 0);
        end
        cs_off();
    endtask

    task automatic do_read(input logic [3:0] a, input int n, input string req);
        logic [7:0] rx;
        cs_on();
        xfer(8'h90 | {4'h0, a}, rx);
        chk("R8 miso during read command", rx, 0);
        for (int k = 0; k < n; k++) begin
            exp_rd.push_back(shadow[a + 4'(k)]);
            xfer(8'h00, rx);
            chk(req, rx, exp_rd.pop_front());
        end
        cs_off();
    endtask

    task automatic do_ignored(input logic [7:0] cmd);
        logic [7:0] rx;
        cs_on();
        xfer(cmd, rx);
        chk("R6 miso during ignored command", rx, 0);
        xfer(8'hAA, rx);
        chk("R6 miso after ignored command", rx, 0);
        xfer(8'h55, rx);
        chk("R6 miso after ignored command", rx, 0);
        cs_off();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d [4];
        logic [7:0] rx;
        for (int i = 0; i < 16; i++) begin
            regs[i]   = 8'(i * 17 + 3);
            shadow[i] = 8'(i * 17 + 3);
        end
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R1 reset state
        chk("R1 miso after reset", spi_miso, 0);
        chk("R1 rf_we after reset", rf_we, 0);

        // R2 R3 R7 burst write then read back
        d = '{8'h59, 8'h23, 8'hA7, 8'h0F};
        do_write(4'h2, d, 4);
        do_read(4'h2, 4, "R3 R7 read burst");
        do_read(4'h7, 2, "R3 read untouched regs");

        // R4 wrap in both directions
        d = '{8'hC1, 8'h3E, 8'h81, 8'h00};
        do_write(4'hE, d, 3);
        do_read(4'hF, 3, "R4 read across wrap");

        // R5 partial byte at select drop
        cs_on();
        exp_wr.push_back({4'h5, 8'h5A});
        shadow[5] = 8'h5A;
        xfer(8'h15, rx);
        xfer(8'h5A, rx);
        xfer(8'hC3, rx, 5);
        cs_off();
        do_read(4'h5, 2, "R5 partial byte not written");

        // R6 ignored command patterns
        do_ignored(8'h03);
        do_ignored(8'h33);
        do_ignored(8'h83);
        do_read(4'h3, 1, "R6 register unchanged after ignored commands");

        // R9 fresh decode after ignored and partial transactions
        d = '{8'hE4, 8'h00, 8'h00, 8'h00};
        do_write(4'h3, d, 1);
        do_read(4'h3, 1, "R9 new transaction decoded");

        tick(10);
        chk("R2 all expected writes seen", exp_wr.size(), 0);
        chk("R1 miso idle at end", spi_miso, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule